// File: doc/BRIEF.md
# VLAN Tag Detect Length Filter

This block watches the receive byte stream of an Ethernet MAC. It counts the bytes of each frame, from the first destination address byte through the last FCS byte. It checks the two bytes that follow the 6-byte source address against two programmable tag-identifier values. Software normally loads one of these values with 8100h and the other with a non-standard tag type. A match on either value marks the frame as VLAN-tagged.

At the end of each frame the block reports whether the frame is too long. An untagged frame may be at most 1518 bytes long. A tagged frame may be at most 1522 bytes long, which leaves room for the extra 4-byte tag. For a tagged frame, the priority and the VLAN identifier are taken from the tag control field and presented as outputs.

Forwarding, buffering and CRC checking are left to the surrounding receive path. That path acts on the drop flag that this block gives at the end of each frame.

Top module: `vlan_len_filter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `vlan_tagged`, `byte_count`, `frame_done`, `frame_drop`, `vlan_pcp` and `vlan_vid` are all zero.
- R2: A byte accepted with `rx_sof` set makes `byte_count` equal to 1 in the next cycle. Each later accepted byte raises `byte_count` by one in the cycle after it is accepted. The count stops at its all-ones value.
- R3: The 13th and 14th bytes of a frame form a 16-bit type value, with the 13th byte as the high-order byte. If this value equals `tag_id_a`, `vlan_tagged` is 1 from the cycle after byte 14 until the next frame start.
- R4: If the type value from bytes 13 and 14 equals `tag_id_b`, `vlan_tagged` is set in the same way as in R3.
- R5: An accepted byte with `rx_sof` set clears `vlan_tagged` in the next cycle. If the type value matches neither identifier, `vlan_tagged` stays 0 for the rest of the frame.
- R6: For an untagged frame, `frame_drop` is 1 together with `frame_done` exactly when the final count is greater than 1518.
- R7: For a tagged frame, `frame_drop` is 1 together with `frame_done` exactly when the final count is greater than 1522. Tagged frames of 1519 to 1522 bytes are therefore accepted.
- R8: `frame_done` is a one-cycle pulse in the cycle after a byte accepted with `rx_eof` set. `frame_drop` is never 1 unless `frame_done` is also 1. After the end of the frame, `byte_count` holds the final count.
- R9: `vlan_pcp` equals bits 7:5 of byte 15. `vlan_vid` equals bits 3:0 of byte 15, followed by all of byte 16. Both values are valid from the cycle after byte 16 until the next frame start.
- R10: When `rx_valid` is low, `rx_data`, `rx_sof` and `rx_eof` are ignored. In that case `byte_count` and `vlan_tagged` keep their values and `frame_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | `rx_data` holds a byte this cycle |
| rx_sof | input | 1 | This byte is the first byte of a frame |
| rx_eof | input | 1 | This byte is the last byte of a frame |
| rx_data | input | 8 | Received byte |
| tag_id_a | input | 16 | First tag-identifier value |
| tag_id_b | input | 16 | Second tag-identifier value |
| vlan_tagged | output | 1 | The current or last frame carries a matching tag |
| byte_count | output | CNT_W | Bytes of the current or last frame |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| frame_drop | output | 1 | The frame is oversize (valid with `frame_done`) |
| vlan_pcp | output | 3 | Priority field of the tag |
| vlan_vid | output | 12 | VLAN identifier of the tag |

## Verification
The cases that are hardest to reach are the length boundaries, because they depend on the tag decision made about 1500 bytes earlier. The stimulus therefore sends long frames of exactly 1518, 1519, 1522 and 1523 bytes, some matched on the first identifier, some on the second, and some on neither. It also sends frames that have idle gaps where `rx_valid` is low. In those gaps, stray `rx_sof`, `rx_eof` and data values are driven, so that a design that does not wait for `rx_valid` would lose count at the boundary.

// File: rtl/vlan_len_filter.sv
module vlan_len_filter #(
  parameter int CNT_W   = 16,
  parameter int STD_MAX = 1518,
  parameter int TAG_MAX = 1522
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [7:0]       rx_data,
  input  logic [15:0]      tag_id_a,
  input  logic [15:0]      tag_id_b,
  output logic             vlan_tagged,
  output logic [CNT_W-1:0] byte_count,
  output logic             frame_done,
  output logic             frame_drop,
  output logic [2:0]       vlan_pcp,
  output logic [11:0]      vlan_vid
);
  localparam logic [CNT_W-1:0] CNT_TOP  = '1;
  localparam logic [CNT_W-1:0] STD_LIM  = CNT_W'(STD_MAX);
  localparam logic [CNT_W-1:0] TAG_LIM  = CNT_W'(TAG_MAX);

  logic [7:0]       type_hi, tci_hi;
  logic [15:0]      tci;
  logic [CNT_W-1:0] next_cnt;
  logic             id_match;

  assign next_cnt = rx_sof ? CNT_W'(1) :
                    (byte_count == CNT_TOP) ? byte_count : byte_count + CNT_W'(1);
  assign id_match = ({type_hi, rx_data} == tag_id_a) || ({type_hi, rx_data} == tag_id_b);
  assign vlan_pcp = tci[15:13];
  assign vlan_vid = tci[11:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_count  <= '0;
      vlan_tagged <= 1'b0;
      type_hi     <= '0;
      tci_hi      <= '0;
      tci         <= '0;
      frame_done  <= 1'b0;
      frame_drop  <= 1'b0;
    end else begin
      frame_done <= rx_valid && rx_eof;
      frame_drop <= 1'b0;
      if (rx_valid) begin
        byte_count <= next_cnt;
        if (rx_sof)                 vlan_tagged <= 1'b0;
        else if (next_cnt == CNT_W'(14)) vlan_tagged <= id_match;
        if (next_cnt == CNT_W'(13)) type_hi <= rx_data;
        if (next_cnt == CNT_W'(15)) tci_hi  <= rx_data;
        if (next_cnt == CNT_W'(16)) tci     <= {tci_hi, rx_data};
        if (rx_eof)
          frame_drop <= next_cnt > ((next_cnt >= CNT_W'(14) && !rx_sof &&
                        (next_cnt == CNT_W'(14) ? id_match : vlan_tagged)) ? TAG_LIM : STD_LIM);
      end
    end
  end

  assert_sof_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_sof |=> byte_count == CNT_W'(1));
  assert_tag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_sof |=> !vlan_tagged);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(byte_count) && $stable(vlan_tagged) && !frame_done);
  assert_drop_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |-> frame_done);
  assert_untagged_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !vlan_tagged |-> frame_drop == (byte_count > STD_LIM));
  assert_tagged_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && vlan_tagged |-> frame_drop == (byte_count > TAG_LIM));
endmodule

// File: tb/test_vlan_len_filter.sv
module test_vlan_len_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic [15:0] tag_id_a = 16'h8100, tag_id_b = 16'h9100;
  logic        vlan_tagged, frame_done, frame_drop;
  logic [15:0] byte_count;
  logic [2:0]  vlan_pcp;
  logic [11:0] vlan_vid;

  vlan_len_filter i_vlan_len_filter (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .tag_id_a(tag_id_a), .tag_id_b(tag_id_b),
    .vlan_tagged(vlan_tagged), .byte_count(byte_count), .frame_done(frame_done),
    .frame_drop(frame_drop), .vlan_pcp(vlan_pcp), .vlan_vid(vlan_vid));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural reference
  byte unsigned head[$];
  int  m_cnt = 0;
  bit  m_tag = 0, m_done = 0, m_drop = 0, m_have16 = 0;
  int  m_pcp = 0, m_vid = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      head.delete(); m_cnt = 0; m_tag = 0; m_done = 0; m_drop = 0; m_have16 = 0;
    end else begin
      m_done = 0; m_drop = 0;
      if (rx_valid) begin
        if (rx_sof) begin head.delete(); m_cnt = 0; m_tag = 0; m_have16 = 0; end
        m_cnt++;
        if (head.size() < 16) head.push_back(rx_data);
        if (m_cnt == 14)
          m_tag = ({head[12], head[13]} == tag_id_a) || ({head[12], head[13]} == tag_id_b);
        if (m_cnt == 16) begin
          m_have16 = 1;
          m_pcp = head[14] >> 5;
          m_vid = ((head[14] & 15) << 8) | head[15];
        end
        if (rx_eof) begin
          m_done = 1;
          m_drop = m_cnt > (m_tag ? 1522 : 1518);
        end
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  bit compare_on = 0;
  always @(negedge clk) if (compare_on && rst_n) begin
    check("R2", "byte_count", int'(byte_count), m_cnt);
    check("R3 R4 R5", "vlan_tagged", int'(vlan_tagged), int'(m_tag));
    check("R8", "frame_done", int'(frame_done), int'(m_done));
    check("R6 R7", "frame_drop", int'(frame_drop), int'(m_drop));
    if (m_have16) begin
      check("R9", "vlan_pcp", int'(vlan_pcp), m_pcp);
      check("R9", "vlan_vid", int'(vlan_vid), m_vid);
    end
  end

  int drops_seen = 0, dones_seen = 0;
  always @(negedge clk) if (rst_n) begin
    if (frame_done) dones_seen++;
    if (frame_drop) drops_seen++;
  end

  task automatic drive(bit v, bit s, bit e, byte unsigned d);
    @(posedge clk); #2;
    rx_valid = v; rx_sof = s; rx_eof = e; rx_data = d;
  endtask

  task automatic send_frame(int len, logic [15:0] ty, logic [15:0] tci, int gap_every);
    for (int i = 1; i <= len; i++) begin
      byte unsigned d;
      d = byte'(i * 7 + 3);
      if (i == 13) d = ty[15:8];
      if (i == 14) d = ty[7:0];
      if (i == 15) d = tci[15:8];
      if (i == 16) d = tci[7:0];
      drive(1, i == 1, i == len, d);
      if (gap_every != 0 && i % gap_every == 0 && i != len) begin
        drive(0, 1, 1, 8'h81);
        drive(0, 0, 1, 8'h00);
      end
    end
    drive(0, 0, 0, 8'h00);
    drive(0, 0, 0, 8'h00);
  endtask

  task automatic expect_drop(string req, int d0, int exp);
    check(req, "drops in frame", drops_seen - d0, exp);
  endtask

  initial begin
    int d0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "byte_count in reset", int'(byte_count), 0);
    check("R1", "flags in reset", int'({vlan_tagged, frame_done, frame_drop}), 0);
    check("R1", "pcp/vid in reset", int'({vlan_pcp, vlan_vid}), 0);
    @(posedge clk); #2 rst_n = 1;
    @(negedge clk);
    check("R1", "byte_count after reset", int'(byte_count), 0);
    compare_on = 1;

    d0 = drops_seen; send_frame(64, 16'h0800, 16'h0000, 0);  expect_drop("R6", d0, 0);
    check("R8", "final count held", int'(byte_count), 64);
    d0 = drops_seen; send_frame(1522, 16'h8100, 16'hA123, 0); expect_drop("R3 R7", d0, 0);
    d0 = drops_seen; send_frame(1523, 16'h8100, 16'h2FFF, 0); expect_drop("R7", d0, 1);
    d0 = drops_seen; send_frame(1522, 16'h9100, 16'hE456, 0); expect_drop("R4 R7", d0, 0);
    d0 = drops_seen; send_frame(1519, 16'h9100, 16'h4001, 5); expect_drop("R4 R10", d0, 0);
    d0 = drops_seen; send_frame(1518, 16'h0800, 16'h0000, 0); expect_drop("R6", d0, 0);
    d0 = drops_seen; send_frame(1519, 16'h0800, 16'h0000, 0); expect_drop("R6", d0, 1);
    d0 = drops_seen; send_frame(1520, 16'h8101, 16'h0000, 7); expect_drop("R5 R6 R10", d0, 1);
    check("R5", "no tag on near miss", int'(vlan_tagged), 0);
    tag_id_b = 16'h88A8;
    d0 = drops_seen; send_frame(1521, 16'h88A8, 16'h7ABC, 0); expect_drop("R4 R7", d0, 0);
    d0 = drops_seen; send_frame(1521, 16'h9100, 16'h7ABC, 0); expect_drop("R4 R6", d0, 1);
    d0 = dones_seen; send_frame(1, 16'h0000, 16'h0000, 0);
    check("R8", "one-byte frame done", dones_seen - d0, 1);
    check("R2", "one-byte count", int'(byte_count), 1);
    d0 = dones_seen; send_frame(20, 16'h8100, 16'hFFFF, 3);
    check("R8 R10", "done once per gapped frame", dones_seen - d0, 1);
    check("R9", "vid held", int'(vlan_vid), 12'hFFF);
    drive(0, 0, 0, 0);
    repeat (4) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule